// File: doc/BRIEF.md
# FIFO Level Interrupt and Error Controller

This block sits beside the transmit and receive FIFOs of an external bus interface and turns their fill levels into interrupt requests. Software picks a trigger point for each direction as a fraction of the FIFO depth. The transmit request asks for more data once the write FIFO has drained to its trigger point. The receive request asks for service once the read FIFO has filled to its trigger point.

The block also gathers three error causes into sticky flags: a write pushed into a full write FIFO, a stalled read, and a hold-off timeout. Software clears the flags by writing ones. A hold-off timer counts interface clock ticks in which the external device keeps its ready or clock-enable signal low during a transaction. When a nonzero limit is passed, the timer raises the timeout error and emits a one-cycle abort pulse. A limit of zero waits without end.

Status is available both raw and through a per-source mask. A single interrupt line is the OR of the masked sources.

Top module: `fifo_irq_err_ctl`

## Requirements
- R1: Raw status bit 0 (transmit request) is 1 one clock after `tx_level` is at or below the transmit threshold. The threshold for `tx_trig_sel` is 0 for code 0, D/4 for 1, D/2 for 2 and 3D/4 for 3, where D = TX_DEPTH.
- R2: Raw status bit 1 (receive request) is 1 one clock after `rx_level` is at or above the receive threshold. The threshold for `rx_trig_sel` is D/8 for code 0, D/4 for 1, D/2 for 2, 3D/4 for 3, 7D/8 for 4 and D for codes 5 to 7, where D = RX_DEPTH.
- R3: Error flag bit 0 (write-full) sets one clock after `wr_strobe` is high while `tx_level` equals TX_DEPTH and `en_wrfull` is 1. A write strobe at any lower level leaves the flag clear.
- R4: Error flag bit 1 (read-stall) sets one clock after `rd_stall` is high while `en_rdstall` is 1.
- R5: While its enable is 0, a write-full or read-stall event leaves its flag unchanged.
- R6: With `max_wait` equal to 0, the timer never raises the timeout flag and never pulses `abort_pulse`, however long the device stalls.
- R7: With `max_wait` = M > 0, the (M+1)-th stall tick of a transaction does two things one clock later: it sets error flag bit 2 (timeout) and drives `abort_pulse` high for exactly one clock. A stall tick is a cycle with `xfer_active`, `if_tick` high and `if_ready` low. After that, no further abort occurs until `xfer_active` has gone low.
- R8: The stall count returns to zero whenever `xfer_active` is low. Ticks with `if_ready` high and cycles without `if_tick` are not counted.
- R9: A cycle with `err_clr_we` high clears every flag whose bit in `err_clr_bits` is 1. It leaves flags with a 0 bit untouched. A clear in the same cycle as a new event for that flag leaves the flag set.
- R10: Raw status bit 2 is the OR of the three error flags. `masked_status` is `raw_status` AND `irq_mask`, bit for bit. `irq` is the OR of `masked_status`.
- R11: While `rst` is high at a clock edge, the error flags, the raw status, `abort_pulse` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | $clog2(TX_DEPTH+1) | Write FIFO occupancy |
| rx_level | input | $clog2(RX_DEPTH+1) | Read FIFO occupancy |
| tx_trig_sel | input | 2 | Transmit trigger code |
| rx_trig_sel | input | 3 | Receive trigger code |
| irq_mask | input | 3 | Mask: bit0 transmit, bit1 receive, bit2 error |
| en_wrfull | input | 1 | Enable for the write-full error |
| en_rdstall | input | 1 | Enable for the read-stall error |
| wr_strobe | input | 1 | Write pushed toward the write FIFO |
| rd_stall | input | 1 | Read-stall event |
| xfer_active | input | 1 | An external transaction is in progress |
| if_tick | input | 1 | Interface clock enable |
| if_ready | input | 1 | External ready / clock-enable level |
| max_wait | input | WAIT_W | Hold-off limit, 0 means wait forever |
| err_clr_we | input | 1 | Write-one-to-clear strobe |
| err_clr_bits | input | 3 | Flags to clear: bit0 write-full, bit1 read-stall, bit2 timeout |
| raw_status | output | 3 | Unmasked sources: bit0 transmit, bit1 receive, bit2 error |
| masked_status | output | 3 | Sources after the mask |
| err_flags | output | 3 | Sticky error flags |
| abort_pulse | output | 1 | One-cycle transaction abort |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with TX_DEPTH 16 and RX_DEPTH 32. At these depths every eighth of the read FIFO is a distinct whole level, so each receive threshold can be swept level by level, with the value just below it. WAIT_W stays at 8. The wait-forever case can then run past 255 stall ticks and push the counter into saturation. Small nonzero limits place the abort boundary within a few ticks, where interleaved ready ticks and a transaction restart can be shown not to move it.

// File: rtl/fiec_pkg.sv
package fiec_pkg;

    localparam int SRC_N = 3;   // transmit, receive, error
    localparam int ERR_N = 3;   // write-full, read-stall, timeout

    typedef enum logic [1:0] {
        TXT_EMPTY   = 2'd0,
        TXT_QUARTER = 2'd1,
        TXT_HALF    = 2'd2,
        TXT_3QTR    = 2'd3
    } tx_trig_e;

    typedef struct packed {
        logic timeout;
        logic rd_stall;
        logic wr_full;
    } err_vec_t;

    typedef struct packed {
        logic err;
        logic rx;
        logic tx;
    } src_vec_t;

    function automatic int tx_threshold(int depth, logic [1:0] sel);
        case (tx_trig_e'(sel))
            TXT_EMPTY:   return 0;
            TXT_QUARTER: return depth / 4;
            TXT_HALF:    return depth / 2;
            default:     return (3 * depth) / 4;
        endcase
    endfunction

    function automatic int rx_threshold(int depth, logic [2:0] sel);
        case (sel)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return (3 * depth) / 4;
            3'd4:    return (7 * depth) / 8;
            default: return depth;
        endcase
    endfunction

endpackage

// File: rtl/fiec_level_trigger.sv
module fiec_level_trigger
    import fiec_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b0,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] level,
    input  logic [2:0]    sel,
    output logic          req
);
    logic hit;

    generate
        if (IS_RX) begin : g_rx
            always_comb hit = int'(level) >= rx_threshold(DEPTH, sel);
        end else begin : g_tx
            always_comb hit = int'(level) <= tx_threshold(DEPTH, sel[1:0]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= hit;
    end
endmodule

// File: rtl/fiec_holdoff_timer.sv
module fiec_holdoff_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_active,
    input  logic              if_tick,
    input  logic              if_ready,
    input  logic [WAIT_W-1:0] max_wait,
    output logic              expire,
    output logic              abort_pulse
);
    logic [WAIT_W-1:0] stall_cnt;
    logic              spent;
    logic              stall_tick;

    always_comb begin
        stall_tick = xfer_active && if_tick && !if_ready && !spent;
        expire     = stall_tick && (max_wait != '0) && (stall_cnt == max_wait);
    end

    always_ff @(posedge clk) begin
        if (rst || !xfer_active) begin
            stall_cnt <= '0;
            spent     <= 1'b0;
        end else if (expire) begin
            spent     <= 1'b1;
        end else if (stall_tick && stall_cnt != '1) begin
            stall_cnt <= stall_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) abort_pulse <= 1'b0;
        else     abort_pulse <= expire;
    end
endmodule

// File: rtl/fiec_err_collect.sv
module fiec_err_collect
    import fiec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  err_vec_t events,
    input  logic     clr_we,
    input  err_vec_t clr_bits,
    output err_vec_t flags
);
    logic [ERR_N-1:0] clr_mask;

    always_comb clr_mask = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_mask) | events;
    end
endmodule

// File: rtl/fifo_irq_err_ctl.sv
module fifo_irq_err_ctl
    import fiec_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    parameter int WAIT_W   = 8,
    localparam int TXC_W = $clog2(TX_DEPTH + 1),
    localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TXC_W-1:0]  tx_level,
    input  logic [RXC_W-1:0]  rx_level,
    input  logic [1:0]        tx_trig_sel,
    input  logic [2:0]        rx_trig_sel,
    input  logic [2:0]        irq_mask,
    input  logic              en_wrfull,
    input  logic              en_rdstall,
    input  logic              wr_strobe,
    input  logic              rd_stall,
    input  logic              xfer_active,
    input  logic              if_tick,
    input  logic              if_ready,
    input  logic [WAIT_W-1:0] max_wait,
    input  logic              err_clr_we,
    input  logic [2:0]        err_clr_bits,
    output logic [2:0]        raw_status,
    output logic [2:0]        masked_status,
    output logic [2:0]        err_flags,
    output logic              abort_pulse,
    output logic              irq
);
    localparam logic [TXC_W-1:0] TX_FULL = TXC_W'(TX_DEPTH);

    logic     tx_req, rx_req, expire;
    err_vec_t events, flags;
    src_vec_t raw;

    fiec_level_trigger #(.DEPTH(TX_DEPTH), .IS_RX(1'b0)) i_tx_trig (
        .clk   (clk),
        .rst   (rst),
        .level (tx_level),
        .sel   ({1'b0, tx_trig_sel}),
        .req   (tx_req)
    );

    fiec_level_trigger #(.DEPTH(RX_DEPTH), .IS_RX(1'b1)) i_rx_trig (
        .clk   (clk),
        .rst   (rst),
        .level (rx_level),
        .sel   (rx_trig_sel),
        .req   (rx_req)
    );

    fiec_holdoff_timer #(.WAIT_W(WAIT_W)) i_timer (
        .clk         (clk),
        .rst         (rst),
        .xfer_active (xfer_active),
        .if_tick     (if_tick),
        .if_ready    (if_ready),
        .max_wait    (max_wait),
        .expire      (expire),
        .abort_pulse (abort_pulse)
    );

    always_comb begin
        events.wr_full  = en_wrfull && wr_strobe && (tx_level == TX_FULL);
        events.rd_stall = en_rdstall && rd_stall;
        events.timeout  = expire;
    end

    fiec_err_collect i_errs (
        .clk      (clk),
        .rst      (rst),
        .events   (events),
        .clr_we   (err_clr_we),
        .clr_bits (err_vec_t'(err_clr_bits)),
        .flags    (flags)
    );

    always_comb begin
        raw.tx        = tx_req;
        raw.rx        = rx_req;
        raw.err       = |flags;
        raw_status    = raw;
        masked_status = raw_status & irq_mask;
        err_flags     = flags;
        irq           = |masked_status;
    end
endmodule

// File: rtl/fiec_checker.sv
module fiec_checker #(
    parameter int WAIT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en_wrfull,
    input logic              en_rdstall,
    input logic              err_clr_we,
    input logic [2:0]        err_clr_bits,
    input logic [WAIT_W-1:0] max_wait,
    input logic [2:0]        err_flags,
    input logic [2:0]        raw_status,
    input logic              abort_pulse,
    input logic              irq
);
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);                                   // R7

    AST_ABORT_FLAGS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> err_flags[2]);                                   // R7

    AST_WAIT_FOREVER: assert property (@(posedge clk) disable iff (rst)
        (max_wait == '0) |=> !abort_pulse);                              // R6

    AST_WRFULL_GATED: assert property (@(posedge clk) disable iff (rst)
        (!en_wrfull && !err_flags[0]) |=> !err_flags[0]);                // R5

    AST_RDSTALL_GATED: assert property (@(posedge clk) disable iff (rst)
        (!en_rdstall && !err_flags[1]) |=> !err_flags[1]);               // R5

    AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flags[0] && !(err_clr_we && err_clr_bits[0])) |=> err_flags[0]); // R9

    AST_FLAG2_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flags[2] && !(err_clr_we && err_clr_bits[2])) |=> err_flags[2]); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (err_flags == '0 && raw_status == '0 && !abort_pulse && !irq)); // R11
endmodule

bind fifo_irq_err_ctl fiec_checker #(.WAIT_W(WAIT_W)) i_fiec_checker (
    .clk          (clk),
    .rst          (rst),
    .en_wrfull    (en_wrfull),
    .en_rdstall   (en_rdstall),
    .err_clr_we   (err_clr_we),
    .err_clr_bits (err_clr_bits),
    .max_wait     (max_wait),
    .err_flags    (err_flags),
    .raw_status   (raw_status),
    .abort_pulse  (abort_pulse),
    .irq          (irq)
);

// File: tb/test_fifo_irq_err_ctl.sv
module test_fifo_irq_err_ctl;
    localparam int TXD = 16;
    localparam int RXD = 32;
    localparam int WW  = 8;
    localparam int TCW = $clog2(TXD + 1);
    localparam int RCW = $clog2(RXD + 1);

    logic clk = 1'b0;
    logic rst;
    logic [TCW-1:0] tx_level;
    logic [RCW-1:0] rx_level;
    logic [1:0] tx_trig_sel;
    logic [2:0] rx_trig_sel, irq_mask, err_clr_bits;
    logic en_wrfull, en_rdstall, wr_strobe, rd_stall;
    logic xfer_active, if_tick, if_ready, err_clr_we;
    logic [WW-1:0] max_wait;
    logic [2:0] raw_status, masked_status, err_flags;
    logic abort_pulse, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [2:0] eflags = '0;

    always #10 clk = ~clk;

    fifo_irq_err_ctl #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .WAIT_W(WW)) i_fifo_irq_err_ctl (
        .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
        .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel), .irq_mask(irq_mask),
        .en_wrfull(en_wrfull), .en_rdstall(en_rdstall), .wr_strobe(wr_strobe),
        .rd_stall(rd_stall), .xfer_active(xfer_active), .if_tick(if_tick),
        .if_ready(if_ready), .max_wait(max_wait), .err_clr_we(err_clr_we),
        .err_clr_bits(err_clr_bits), .raw_status(raw_status),
        .masked_status(masked_status), .err_flags(err_flags),
        .abort_pulse(abort_pulse), .irq(irq)
    );

    function automatic int exp_tx_thr(int sel);
        return (TXD * sel) / 4;
    endfunction

    function automatic int exp_rx_thr(int sel);
        int eighths[5] = '{1, 2, 4, 6, 7};
        return (sel >= 5) ? RXD : (RXD * eighths[sel]) / 8;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_strobe = 0; rd_stall = 0; err_clr_we = 0; err_clr_bits = 0;
        xfer_active = 0; if_tick = 0; if_ready = 1;
    endtask

    task automatic clear_all();
        err_clr_we = 1; err_clr_bits = 3'b111;
        step();
        err_clr_we = 0; err_clr_bits = 0;
        eflags = '0;
    endtask

    task automatic check_status(string req, logic [2:0] mask, bit tx_e, bit rx_e, logic [2:0] fl);
        logic [2:0] raw_e;
        raw_e = {|fl, rx_e, tx_e};
        check(req, raw_status, raw_e);
        check("R10 masked", masked_status, raw_e & mask);
        check("R10 irq", irq, |(raw_e & mask));
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog expired actual=running expected=finished");
        n_fail++; n_tests++;
        if (!done) begin
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234abcd));
        rst = 1; tx_level = 0; rx_level = 0; tx_trig_sel = 0; rx_trig_sel = 0;
        irq_mask = 3'b111; en_wrfull = 1; en_rdstall = 1; max_wait = 0;
        idle_inputs();
        wr_strobe = 1; rd_stall = 1;
        @(negedge clk); step();
        // R11: reset state while rst held
        check("R11 raw", raw_status, 0);
        check("R11 flags", err_flags, 0);
        check("R11 abort", abort_pulse, 0);
        check("R11 irq", irq, 0);
        idle_inputs();
        rst = 0;
        step();

        // R1: exhaustive transmit threshold sweep
        irq_mask = 3'b001;
        for (int s = 0; s < 4; s++)
            for (int l = 0; l <= TXD; l++) begin
                tx_trig_sel = 2'(s); tx_level = TCW'(l);
                step();
                check_status("R1 tx_req", irq_mask, l <= exp_tx_thr(s), raw_status[1], 3'b0);
            end

        // R2: exhaustive receive threshold sweep
        irq_mask = 3'b010;
        for (int s = 0; s < 8; s++)
            for (int l = 0; l <= RXD; l++) begin
                rx_trig_sel = 3'(s); rx_level = RCW'(l);
                step();
                check_status("R2 rx_req", irq_mask, raw_status[0], l >= exp_rx_thr(s), 3'b0);
            end

        // R3: write strobe below full does nothing, at full sets bit 0
        irq_mask = 3'b100; tx_level = TCW'(TXD - 1); wr_strobe = 1;
        step();
        check("R3 below full", err_flags, 3'b000);
        tx_level = TCW'(TXD);
        step();
        wr_strobe = 0;
        check("R3 at full", err_flags, 3'b001);
        check("R10 irq from error", irq, 1);
        // R9: clear bit 1 only leaves bit 0
        err_clr_we = 1; err_clr_bits = 3'b010;
        step();
        check("R9 other bits kept", err_flags, 3'b001);
        err_clr_bits = 3'b001;
        step();
        check("R9 cleared", err_flags, 3'b000);
        err_clr_we = 0;

        // R5: disabled causes ignored
        en_wrfull = 0; en_rdstall = 0; wr_strobe = 1; rd_stall = 1;
        step();
        wr_strobe = 0; rd_stall = 0;
        check("R5 disabled", err_flags, 3'b000);
        check("R5 irq", irq, 0);
        en_wrfull = 1; en_rdstall = 1;

        // R4 and R9: event and clear in the same cycle keep the flag
        rd_stall = 1; err_clr_we = 1; err_clr_bits = 3'b010;
        step();
        rd_stall = 0; err_clr_we = 0;
        check("R4 R9 same-cycle", err_flags, 3'b010);
        clear_all();
        check("R9 clear all", err_flags, 3'b000);

        // R7: limit 3, abort on the 4th stall tick
        max_wait = 3; xfer_active = 1; if_tick = 1; if_ready = 0;
        for (int k = 1; k <= 3; k++) begin
            step();
            check("R7 before limit", {abort_pulse, err_flags[2]}, 2'b00);
        end
        step();
        check("R7 abort", {abort_pulse, err_flags[2]}, 2'b11);
        step();
        check("R7 one cycle", abort_pulse, 0);
        for (int k = 0; k < 8; k++) step();
        check("R7 once per transaction", abort_pulse, 0);
        xfer_active = 0;
        step();
        clear_all();

        // R8: ready ticks and idle cycles are not counted, restart clears count
        xfer_active = 1;
        for (int k = 0; k < 2; k++) begin if_ready = 0; if_tick = 1; step(); end
        xfer_active = 0; step(); xfer_active = 1;
        for (int k = 0; k < 3; k++) begin
            if_ready = 0; if_tick = 1; step();
            if_ready = 1; step();
            if_ready = 0; if_tick = 0; step();
        end
        check("R8 no abort yet", {abort_pulse, err_flags[2]}, 2'b00);
        if_tick = 1;
        step();
        check("R8 abort at 4th counted tick", {abort_pulse, err_flags[2]}, 2'b11);
        xfer_active = 0; if_ready = 1;
        step();
        clear_all();

        // R6: wait forever past counter saturation
        max_wait = 0; xfer_active = 1; if_tick = 1; if_ready = 0;
        begin
            bit seen = 0;
            for (int k = 0; k < 300; k++) begin
                step();
                if (abort_pulse || err_flags[2]) seen = 1;
            end
            check("R6 wait forever", seen, 0);
        end
        idle_inputs();
        step();

        // Random mix of levels, triggers, masks, errors and clears
        for (int it = 0; it < 400; it++) begin
            int tl, rl, ts, rs;
            logic [2:0] ev, clr;
            tl = int'($urandom_range(TXD, 0)); rl = int'($urandom_range(RXD, 0));
            ts = int'($urandom_range(3, 0));   rs = int'($urandom_range(7, 0));
            if ($urandom_range(3, 0) == 0) tl = TXD;
            tx_level = TCW'(tl); rx_level = RCW'(rl);
            tx_trig_sel = 2'(ts); rx_trig_sel = 3'(rs);
            irq_mask = 3'($urandom);
            en_wrfull = 1'($urandom); en_rdstall = 1'($urandom);
            wr_strobe = 1'($urandom); rd_stall = 1'($urandom);
            err_clr_we = 1'($urandom); err_clr_bits = 3'($urandom);
            ev  = {1'b0, en_rdstall & rd_stall, en_wrfull & wr_strobe & (tl == TXD)};
            clr = err_clr_we ? err_clr_bits : 3'b0;
            eflags = (eflags & ~clr) | ev;
            step();
            check("R3 R4 R5 R9 flags", err_flags, eflags);
            check_status("R1 R2 R10 status", irq_mask, tl <= exp_tx_thr(ts),
                         rl >= exp_rx_thr(rs), eflags);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule